// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Committed Configuration

This block drives four pulse outputs, one per channel, from a small word-addressed register window. Each channel has its own period length, its own high-time length and a control word that picks the waveform mode and the output polarity. Both lengths are counted in system clock cycles. The only waveform mode provided is trailing-edge mark-space. In that mode the output is at its active level at the start of each period and drops once the high-time has elapsed.

Software never changes a running waveform directly. Every write lands in a pending copy of the configuration. Setting the commit bit in the global word moves the pending period, high-time, control and enable settings of all four channels into the live set on one clock edge, and all channel counters restart together. Channels therefore change in lockstep and stay phase-aligned.

Each channel is a three-state machine. OFF is entered when the channel is not running. MARK is the active part of the period. SPACE is the idle part of the period. The named transitions are:
- start: OFF to MARK or SPACE, when a commit turns the channel on.
- mark_end: MARK to SPACE, when the count reaches the high-time.
- wrap: SPACE to MARK, at the start of a new period.
- restart: any state back to the level for count 0, on a commit.
- stop: MARK or SPACE to OFF.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads 0 and every output is low.
- R2: The address map and the fields are as follows.
  - Global word at 0x00: enables in bits [3:0]; bit 31 commits.
  - Channel n control at 0x14+16n: mode in bits [1:0], polarity in bit 3, a stored hold flag in bit 8. All other bits are dropped and read as 0.
  - Channel n period at 0x18+16n and high-time at 0x20+16n, each 16 bits, zero-extended on read.
  - Reads return the pending values. Unmapped addresses read 0 and ignore writes.
- R3: Writes to pending registers, including a global write with bit 31 clear, leave every output unchanged.
- R4: A write to 0x00 with bit 31 set commits all pending settings on that clock edge, using the enables carried in the same write. All counters restart at 0. Bit 31 always reads back as 0.
- R5: While a channel is running with period P ≥ 2, the output k cycles after the commit edge is active when (k mod P) < high-time, and inactive otherwise.
- R6: A high-time greater than or equal to a nonzero period keeps the output active for the whole period.
- R7: A high-time of 0 keeps the output inactive.
- R8: With a period of 0 or 1 the counter stays at 0. The output is active exactly when the high-time is nonzero.
- R9: A channel that is not enabled, or whose mode is not 1, holds its counter at 0 and drives the inactive level. The inactive level is low, or high when the polarity bit is 1.
- R10: The polarity bit inverts the channel output, so the active level becomes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; counting unit |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 4 | One pulse output per channel |

## Verification
The hardest situation to reach from the ports is a commit that lands mid-period, while pending values differ from the live ones on several channels at once. Only then does a missed restart, a stale enable or a leaked pending write show up as a phase error. The stimulus therefore interleaves random pending writes and commits with random idle gaps, so commits fall at arbitrary counter phases. Each output is compared every cycle against a model that counts cycles since the last commit. Directed settings cover a full-period high-time, a zero high-time, periods of 0 and 1, an unsupported mode and inverted polarity.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    // register word width and layout constants that software decodes
    localparam int REG_W     = 32;
    localparam int GLB_ADDR  = 'h00;
    localparam int CH_BASE   = 'h14;
    localparam int CH_STRIDE = 16;
    localparam int RANGE_OFS = 4;
    localparam int DUTY_OFS  = 12;
    localparam int UPD_BIT   = 31;
    localparam int POL_BIT   = 3;
    localparam int HOLD_BIT  = 8;

    localparam logic [1:0] MODE_TE = 2'd1;

    typedef struct packed {
        logic       hold;
        logic       pol;
        logic [1:0] mode;
    } ch_ctrl_t;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_MARK  = 2'd1,
        CH_SPACE = 2'd2
    } ch_state_e;

    function automatic ch_ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
        ch_ctrl_t c;
        c.mode = w[1:0];
        c.pol  = w[POL_BIT];
        c.hold = w[HOLD_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(input ch_ctrl_t c);
        logic [REG_W-1:0] w;
        w           = '0;
        w[1:0]      = c.mode;
        w[POL_BIT]  = c.pol;
        w[HOLD_BIT] = c.hold;
        return w;
    endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 16,
    parameter int AW    = 8
)(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [AW-1:0]                 bus_addr,
    input  logic [REG_W-1:0]              bus_wdata,
    input  logic                          bus_we,
    output logic [REG_W-1:0]              bus_rdata,
    output logic                          commit,
    output logic [NCH-1:0]                act_en_q,
    output logic [NCH-1:0]                act_en_d,
    output ch_ctrl_t [NCH-1:0]            act_ctrl_q,
    output ch_ctrl_t [NCH-1:0]            act_ctrl_d,
    output logic [NCH-1:0][CNT_W-1:0]     act_range_q,
    output logic [NCH-1:0][CNT_W-1:0]     act_range_d,
    output logic [NCH-1:0][CNT_W-1:0]     act_duty_q,
    output logic [NCH-1:0][CNT_W-1:0]     act_duty_d
);

    localparam int PAD_W = REG_W - CNT_W;

    logic                      hit_glb;
    logic [NCH-1:0]            hit_ctrl;
    logic [NCH-1:0]            hit_range;
    logic [NCH-1:0]            hit_duty;

    logic [NCH-1:0]            sh_en;
    ch_ctrl_t [NCH-1:0]        sh_ctrl;
    logic [NCH-1:0][CNT_W-1:0] sh_range;
    logic [NCH-1:0][CNT_W-1:0] sh_duty;

    assign hit_glb = (bus_addr == AW'(GLB_ADDR));
    assign commit  = bus_we && hit_glb && bus_wdata[UPD_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_en <= '0;
        end else if (bus_we && hit_glb) begin
            sh_en <= bus_wdata[NCH-1:0];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan_regs
        localparam int CH_ADDR = CH_BASE + g * CH_STRIDE;

        assign hit_ctrl[g]  = (bus_addr == AW'(CH_ADDR));
        assign hit_range[g] = (bus_addr == AW'(CH_ADDR + RANGE_OFS));
        assign hit_duty[g]  = (bus_addr == AW'(CH_ADDR + DUTY_OFS));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_ctrl[g]  <= '0;
                sh_range[g] <= '0;
                sh_duty[g]  <= '0;
            end else if (bus_we) begin
                if (hit_ctrl[g]) begin
                    sh_ctrl[g] <= ctrl_from_word(bus_wdata);
                end
                if (hit_range[g]) begin
                    sh_range[g] <= bus_wdata[CNT_W-1:0];
                end
                if (hit_duty[g]) begin
                    sh_duty[g] <= bus_wdata[CNT_W-1:0];
                end
            end
        end
    end

    // live set: next value is the pending set on a commit edge
    always_comb begin
        act_en_d    = act_en_q;
        act_ctrl_d  = act_ctrl_q;
        act_range_d = act_range_q;
        act_duty_d  = act_duty_q;
        if (commit) begin
            act_en_d    = bus_wdata[NCH-1:0];
            act_ctrl_d  = sh_ctrl;
            act_range_d = sh_range;
            act_duty_d  = sh_duty;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_en_q    <= '0;
            act_ctrl_q  <= '0;
            act_range_q <= '0;
            act_duty_q  <= '0;
        end else begin
            act_en_q    <= act_en_d;
            act_ctrl_q  <= act_ctrl_d;
            act_range_q <= act_range_d;
            act_duty_q  <= act_duty_d;
        end
    end

    // read path returns pending values; commit bit is never stored
    always_comb begin
        bus_rdata = '0;
        if (hit_glb) begin
            bus_rdata[NCH-1:0] = sh_en;
        end
        for (int i = 0; i < NCH; i++) begin
            if (hit_ctrl[i]) begin
                bus_rdata = ctrl_to_word(sh_ctrl[i]);
            end
            if (hit_range[i]) begin
                bus_rdata = {{PAD_W{1'b0}}, sh_range[i]};
            end
            if (hit_duty[i]) begin
                bus_rdata = {{PAD_W{1'b0}}, sh_duty[i]};
            end
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 16
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run_d,
    input  logic             pol_q,
    input  logic [CNT_W-1:0] range_d,
    input  logic [CNT_W-1:0] duty_d,
    output logic [CNT_W-1:0] cnt_q,
    output logic             pwm_o
);

    ch_state_e        state_q;
    ch_state_e        state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             wrap;
    logic             mark_ok;

    always_comb begin
        wrap = (range_d <= CNT_W'(1)) || (cnt_q >= range_d - CNT_W'(1));
        if (restart || !run_d || wrap) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
        mark_ok = (cnt_d < duty_d);

        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (run_d) begin                         // start
                    state_d = mark_ok ? CH_MARK : CH_SPACE;
                end
            end
            CH_MARK: begin
                if (!run_d) begin                        // stop
                    state_d = CH_OFF;
                end else if (!mark_ok) begin             // mark_end / restart
                    state_d = CH_SPACE;
                end
            end
            CH_SPACE: begin
                if (!run_d) begin                        // stop
                    state_d = CH_OFF;
                end else if (mark_ok) begin              // wrap / restart
                    state_d = CH_MARK;
                end
            end
            default: state_d = CH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        pwm_o = (state_q == CH_MARK) ^ pol_q;
    end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 16,
    parameter int AW    = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    input  logic             bus_we,
    output logic [31:0]      bus_rdata,
    output logic [3:0]       pwm_out
);

    logic                      commit;
    logic [NCH-1:0]            act_en_q;
    logic [NCH-1:0]            act_en_d;
    ch_ctrl_t [NCH-1:0]        act_ctrl_q;
    ch_ctrl_t [NCH-1:0]        act_ctrl_d;
    logic [NCH-1:0][CNT_W-1:0] act_range_q;
    logic [NCH-1:0][CNT_W-1:0] act_range_d;
    logic [NCH-1:0][CNT_W-1:0] act_duty_q;
    logic [NCH-1:0][CNT_W-1:0] act_duty_d;
    logic [NCH-1:0][CNT_W-1:0] cnt_q;
    logic [NCH-1:0]            act_run;
    logic [NCH-1:0]            act_pol;
    logic [NCH-1:0]            run_d;

    pwm_bank_regs #(
        .NCH   (NCH),
        .CNT_W (CNT_W),
        .AW    (AW)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_we      (bus_we),
        .bus_rdata   (bus_rdata),
        .commit      (commit),
        .act_en_q    (act_en_q),
        .act_en_d    (act_en_d),
        .act_ctrl_q  (act_ctrl_q),
        .act_ctrl_d  (act_ctrl_d),
        .act_range_q (act_range_q),
        .act_range_d (act_range_d),
        .act_duty_q  (act_duty_q),
        .act_duty_d  (act_duty_d)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign run_d[g]   = act_en_d[g] && (act_ctrl_d[g].mode == MODE_TE);
        assign act_run[g] = act_en_q[g] && (act_ctrl_q[g].mode == MODE_TE);
        assign act_pol[g] = act_ctrl_q[g].pol;

        pwm_bank_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (commit),
            .run_d   (run_d[g]),
            .pol_q   (act_pol[g]),
            .range_d (act_range_d[g]),
            .duty_d  (act_duty_d[g]),
            .cnt_q   (cnt_q[g]),
            .pwm_o   (pwm_out[g])
        );
    end

    logic unused_live;
    assign unused_live = ^{act_ctrl_q, act_range_q, act_duty_q, act_run, cnt_q};

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
    parameter int NCH   = 4,
    parameter int CNT_W = 16,
    parameter int AW    = 8
)(
    input logic                      clk,
    input logic                      rst_n,
    input logic [AW-1:0]             bus_addr,
    input logic [31:0]               bus_rdata,
    input logic [3:0]                pwm_out,
    input logic                      commit,
    input logic [NCH-1:0]            act_run,
    input logic [NCH-1:0]            act_pol,
    input logic [NCH-1:0][CNT_W-1:0] act_range_q,
    input logic [NCH-1:0][CNT_W-1:0] act_duty_q,
    input logic [NCH-1:0][CNT_W-1:0] cnt_q
);

    p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pwm_out == 4'b0000));

    p_upd_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> !bus_rdata[31]);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
            commit |=> (cnt_q[i] == '0));

        p_live_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !commit |=> ($stable(act_range_q[i]) && $stable(act_duty_q[i])
                         && $stable(act_run[i]) && $stable(act_pol[i])));

        p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (act_run[i] && act_range_q[i] > 1) |-> (cnt_q[i] < act_range_q[i]));

        p_full_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (act_run[i] && act_range_q[i] != '0 && act_duty_q[i] >= act_range_q[i])
            |-> (pwm_out[i] != act_pol[i]));

        p_zero_duty_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (act_run[i] && act_duty_q[i] == '0) |-> (pwm_out[i] == act_pol[i]));

        p_small_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (act_range_q[i] <= 1) |-> (cnt_q[i] == '0));

        p_off_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !act_run[i] |-> ((pwm_out[i] == act_pol[i]) && (cnt_q[i] == '0)));
    end

endmodule

bind pwm_bank pwm_bank_chk #(
    .NCH   (NCH),
    .CNT_W (CNT_W),
    .AW    (AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .pwm_out     (pwm_out),
    .commit      (commit),
    .act_run     (act_run),
    .act_pol     (act_pol),
    .act_range_q (act_range_q),
    .act_duty_q  (act_duty_q),
    .cnt_q       (cnt_q)
);

// File: tb/pwm_bank_bench.sv
`timescale 1ns/1ps
module pwm_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_bank u_pwm_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // model state
    logic [3:0]  m_sh_en, m_a_en;
    logic [1:0]  m_sh_mode[4], m_a_mode[4];
    logic        m_sh_pol[4], m_a_pol[4], m_sh_hold[4];
    logic [15:0] m_sh_rng[4], m_a_rng[4], m_sh_duty[4], m_a_duty[4];
    int          m_k;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic int ctrl_addr(input int ch);  return 'h14 + 16 * ch; endfunction
    function automatic int rng_addr(input int ch);   return 'h18 + 16 * ch; endfunction
    function automatic int duty_addr(input int ch);  return 'h20 + 16 * ch; endfunction

    function automatic bit m_run(input int ch);
        return m_a_en[ch] && (m_a_mode[ch] == 2'd1);
    endfunction

    function automatic logic exp_out(input int ch);
        int pos;
        if (!m_run(ch)) return m_a_pol[ch];
        pos = (m_a_rng[ch] <= 1) ? 0 : (m_k % int'(m_a_rng[ch]));
        return logic'(pos < int'(m_a_duty[ch])) ^ m_a_pol[ch];
    endfunction

    function automatic string exp_tag(input int ch);
        if (!m_run(ch)) return "R9";
        if (m_a_rng[ch] <= 1) return "R8";
        if (m_a_duty[ch] >= m_a_rng[ch]) return "R6";
        if (m_a_duty[ch] == 0) return "R7";
        if (m_a_pol[ch]) return "R10";
        return "R5";
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        for (int ch = 0; ch < 4; ch++) begin
            if (int'(a) == ctrl_addr(ch))
                return {23'd0, m_sh_hold[ch], 4'd0, m_sh_pol[ch], 1'b0, m_sh_mode[ch]};
            if (int'(a) == rng_addr(ch))  return {16'd0, m_sh_rng[ch]};
            if (int'(a) == duty_addr(ch)) return {16'd0, m_sh_duty[ch]};
        end
        if (a == 8'h00) return {28'd0, m_sh_en};
        return 32'd0;
    endfunction

    task automatic model_edge();
        if (!rst_n) begin
            m_sh_en = '0; m_a_en = '0; m_k = 0;
            for (int ch = 0; ch < 4; ch++) begin
                m_sh_mode[ch] = '0; m_a_mode[ch] = '0; m_sh_pol[ch] = 0; m_a_pol[ch] = 0;
                m_sh_hold[ch] = 0; m_sh_rng[ch] = '0; m_a_rng[ch] = '0;
                m_sh_duty[ch] = '0; m_a_duty[ch] = '0;
            end
            return;
        end
        m_k++;
        if (bus_we) begin
            if (bus_addr == 8'h00) begin
                m_sh_en = bus_wdata[3:0];
                if (bus_wdata[31]) begin
                    m_a_en = bus_wdata[3:0];
                    for (int ch = 0; ch < 4; ch++) begin
                        m_a_mode[ch] = m_sh_mode[ch]; m_a_pol[ch] = m_sh_pol[ch];
                        m_a_rng[ch] = m_sh_rng[ch];   m_a_duty[ch] = m_sh_duty[ch];
                    end
                    m_k = 0;
                end
            end
            for (int ch = 0; ch < 4; ch++) begin
                if (int'(bus_addr) == ctrl_addr(ch)) begin
                    m_sh_mode[ch] = bus_wdata[1:0];
                    m_sh_pol[ch]  = bus_wdata[3];
                    m_sh_hold[ch] = bus_wdata[8];
                end
                if (int'(bus_addr) == rng_addr(ch))  m_sh_rng[ch]  = bus_wdata[15:0];
                if (int'(bus_addr) == duty_addr(ch)) m_sh_duty[ch] = bus_wdata[15:0];
            end
        end
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (rst_n) begin
            for (int ch = 0; ch < 4; ch++)
                chk(exp_tag(ch), {31'd0, pwm_out[ch]}, {31'd0, exp_out(ch)});
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp_read(a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        chk("R1", {28'd0, pwm_out}, 32'd0);
        rd(8'h00, "R1");
        for (int ch = 0; ch < 4; ch++) begin
            rd(8'(ctrl_addr(ch)), "R1");
            rd(8'(rng_addr(ch)), "R1");
            rd(8'(duty_addr(ch)), "R1");
        end

        // R2 / R3: pending writes, no effect before commit
        wr(8'(ctrl_addr(0)), 32'h0000_0001); wr(8'(rng_addr(0)), 32'd5); wr(8'(duty_addr(0)), 32'd2);
        wr(8'(ctrl_addr(1)), 32'h0000_0009); wr(8'(rng_addr(1)), 32'd6); wr(8'(duty_addr(1)), 32'd3);
        wr(8'(ctrl_addr(2)), 32'h0000_0001); wr(8'(rng_addr(2)), 32'd4); wr(8'(duty_addr(2)), 32'd9);
        wr(8'(ctrl_addr(3)), 32'hFFFF_FEF5); wr(8'(rng_addr(3)), 32'h0001_0000); wr(8'(duty_addr(3)), 32'd1);
        wr(8'h00, 32'h0000_000F);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'(ctrl_addr(3)), "R2");
        rd(8'(rng_addr(3)), "R2");
        rd(8'h04, "R2");
        rd(8'h00, "R2");
        idle(4);
        chk("R3", {28'd0, pwm_out}, 32'd0);

        // R4: commit, then R5 / R6 / R8 / R10 waveforms
        wr(8'h00, 32'h8000_000F);
        rd(8'h00, "R4");
        idle(25);

        // commit mid-period with new settings: R7, R9
        wr(8'(ctrl_addr(0)), 32'h0000_0002);
        wr(8'(duty_addr(1)), 32'd0);
        wr(8'(ctrl_addr(2)), 32'h0000_0108);
        wr(8'(ctrl_addr(1)), 32'hFFFF_FFFF);
        rd(8'(ctrl_addr(1)), "R2");
        wr(8'(ctrl_addr(1)), 32'h0000_0009);
        wr(8'h00, 32'h8000_000B);
        rd(8'h00, "R4");
        idle(15);

        // random pending writes and commits at arbitrary phases
        for (int it = 0; it < 80; it++) begin
            int ch;
            int sel;
            ch  = int'($urandom_range(3, 0));
            sel = int'($urandom_range(5, 0));
            case (sel)
                0: wr(8'(ctrl_addr(ch)), $urandom() & 32'hFFFF_FFF1 | 32'h1);
                1: wr(8'(ctrl_addr(ch)), $urandom());
                2: wr(8'(rng_addr(ch)), $urandom_range(12, 0));
                3: wr(8'(duty_addr(ch)), $urandom_range(14, 0));
                4: wr(8'h00, {1'b1, 27'd0, 4'($urandom())});
                default: wr(8'($urandom_range(8'h5F, 0)), $urandom());
            endcase
            rd(8'($urandom_range(8'h5F, 0)), "R2");
            idle(int'($urandom_range(12, 0)));
        end
        wr(8'h00, 32'h8000_000F);
        idle(30);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule